// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit steers a four-stage pipeline (fetch, decode/operand-fetch, execute, write-back) around read-after-write dependences and taken branches. Each cycle it compares the two source registers the decode stage wants to read against the destination of the instruction in execute. When one matches, the unit acts according to the selected policy. In forwarding mode it points the operand multiplexer at the execute result, so the pipeline never slows. In stall-only mode it freezes the program counter, the fetch register and the decode register, and sends a bubble into execute in place of the dependent instruction.

The register file handles a write and a read of the same register in one cycle, so a producer already in write-back is never a hazard. Register 0 is a constant destination and never matches. When the execute stage reports a taken branch, the two younger instructions in fetch and decode become bubbles. A bubble has its register and memory write enables cleared. The flush outranks any stall in the same cycle.

The unit is combinational from its pipeline inputs to its outputs. The clock and the active-low reset pace its checks, and while reset is low the unit keeps both younger stages bubbled.

Top module: `hazard_ctrl`

## Requirements
- R1: In forwarding mode (`fwd_mode_i`=1), when operand A is used, `ex_we_i`=1, and `ex_rd_i` equals `dof_rs_a_i` and is not 0, `fwd_sel_a_o` is 1 (execute result) and `hold_front_o` is 0.
- R2: The same rule as R1 applies to operand B through `dof_rs_b_i` and `fwd_sel_b_o`. Both operands can forward in the same cycle.
- R3: Forwarding takes only the execute-stage producer. When execute and write-back both write the matching register, the select is 1. A match with write-back alone gives select 0 (register file).
- R4: A destination of register 0 never causes a forward, a hold or a bubble.
- R5: In stall-only mode (`fwd_mode_i`=0), an execute-stage match on either used operand drives `hold_front_o`=1 and `dof_bubble_o`=1, with both selects 0.
- R6: A match with the write-back destination alone never causes a hold or a bubble in either mode.
- R7: A source whose use flag is 0 never causes a forward or a hold.
- R8: When `br_taken_i`=1, `if_bubble_o` and `dof_bubble_o` are 1 and `hold_front_o` is 0, even when a data hazard is present. The forwarding selects keep their normal values.
- R9: With no execute-stage match and no taken branch, all selects, the hold and both bubbles are 0.
- R10: In forwarding mode `hold_front_o` is never 1.
- R11: While `rst_n` is 0, `if_bubble_o` and `dof_bubble_o` are 1 and `hold_front_o` and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset; bubbles the younger stages while low |
| fwd_mode_i | input | 1 | 1 selects forwarding, 0 selects stall-only |
| dof_rs_a_i | input | 5 | Decode-stage source register A |
| dof_use_a_i | input | 1 | Source A is read by the decode-stage instruction |
| dof_rs_b_i | input | 5 | Decode-stage source register B |
| dof_use_b_i | input | 1 | Source B is read by the decode-stage instruction |
| ex_rd_i | input | 5 | Execute-stage destination register |
| ex_we_i | input | 1 | Execute-stage register write enable |
| wb_rd_i | input | 5 | Write-back destination register |
| wb_we_i | input | 1 | Write-back register write enable |
| br_taken_i | input | 1 | Branch in execute is taken |
| fwd_sel_a_o | output | 1 | Operand A mux: 0 register file, 1 execute result |
| fwd_sel_b_o | output | 1 | Operand B mux: 0 register file, 1 execute result |
| hold_front_o | output | 1 | Freeze PC, fetch and decode registers |
| dof_bubble_o | output | 1 | Send a bubble into execute instead of the decode instruction |
| if_bubble_o | output | 1 | Replace the fetched instruction with a bubble |

## Verification
A faulty comparator or a wrong policy decode shows at the outputs in the same cycle as the offending inputs, because no register lies between the inputs and the outputs. A wrong comparator shows as a missing or spurious select. A wrong policy shows as a hold in forwarding mode, or as a hold with no bubble. Faults in the flush priority or the register-0 exclusion appear only when a branch and a hazard coincide, or when a destination is zero. The vectors therefore pair those conditions on purpose.

// File: rtl/hc_pkg.sv
// Shared definitions for the hazard control unit.
// Assumes a register file with a write-then-read cycle, so only the
// execute stage can supply a value that the file does not yet hold.
package hc_pkg;
    typedef enum logic {
        SEL_REGFILE = 1'b0,
        SEL_EXEC    = 1'b1
    } fwd_sel_t;
endpackage

// File: rtl/hc_src_match.sv
// One operand comparator: flags that the decode-stage source is produced by
// the instruction currently in execute. Register 0 never matches.
// Assumes a write-back producer is visible through the register file.
module hc_src_match #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_i,
    input  logic [AW-1:0] rs_i,
    input  logic          ex_we_i,
    input  logic [AW-1:0] ex_rd_i,
    output logic          ex_hit_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic dest_live;

    // Purpose: the execute instruction really writes a non-constant register.
    always_comb dest_live = ex_we_i && (ex_rd_i != ZERO_REG);

    // Purpose: raise a hit when a used source reads that live destination.
    always_comb ex_hit_o = use_i && dest_live && (rs_i == ex_rd_i);

    // R4
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd_i == ZERO_REG) |-> !ex_hit_o);

    // R7
    unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_i |-> !ex_hit_o);
endmodule

// File: rtl/hc_policy.sv
// Turns per-operand hit flags into forwarding selects, a front-end hold and
// bubble controls. A taken branch flushes both younger stages and overrides
// any hold. While reset is low both younger stages are kept bubbled.
module hc_policy #(
    parameter int NSRC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fwd_mode_i,
    input  logic [NSRC-1:0]       hit_i,
    input  logic                  br_taken_i,
    output hc_pkg::fwd_sel_t      fwd_sel_o [NSRC],
    output logic                  hold_o,
    output logic                  dof_bubble_o,
    output logic                  if_bubble_o
);
    import hc_pkg::*;

    logic any_hit;
    logic flush;

    // Purpose: collapse the operand hits into one dependence flag.
    always_comb any_hit = |hit_i;

    // Purpose: a flush comes from a taken branch or from reset being held.
    always_comb flush = br_taken_i || !rst_n;

    // Purpose: per-operand mux select, active only in forwarding mode.
    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        always_comb
            fwd_sel_o[g] = (rst_n && fwd_mode_i && hit_i[g]) ? SEL_EXEC : SEL_REGFILE;
    end

    // Purpose: hold and bubble decisions, with the flush outranking a hold.
    always_comb begin
        hold_o       = 1'b0;
        dof_bubble_o = 1'b0;
        if_bubble_o  = 1'b0;
        if (flush) begin
            dof_bubble_o = 1'b1;
            if_bubble_o  = 1'b1;
        end else if (!fwd_mode_i && any_hit) begin
            hold_o       = 1'b1;
            dof_bubble_o = 1'b1;
        end
    end

    // R10
    fwd_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_mode_i |-> !hold_o);

    // R5
    hold_has_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (dof_bubble_o && !if_bubble_o));

    // R8
    flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_i |-> (if_bubble_o && dof_bubble_o && !hold_o));
endmodule

// File: rtl/hazard_ctrl.sv
// Hazard control for a fetch / decode / execute / write-back pipeline.
// Compares both decode sources against the execute destination and applies
// the forwarding or stall-only policy. Also flushes after a taken branch.
// Assumes: the branch outcome arrives from execute; outputs are combinational.
module hazard_ctrl #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_mode_i,
    input  logic [AW-1:0] dof_rs_a_i,
    input  logic          dof_use_a_i,
    input  logic [AW-1:0] dof_rs_b_i,
    input  logic          dof_use_b_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_we_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_we_i,
    input  logic          br_taken_i,
    output logic          fwd_sel_a_o,
    output logic          fwd_sel_b_o,
    output logic          hold_front_o,
    output logic          dof_bubble_o,
    output logic          if_bubble_o
);
    import hc_pkg::*;

    logic [AW-1:0]   src_addr [NSRC];
    logic [NSRC-1:0] src_use;
    logic [NSRC-1:0] hit;
    fwd_sel_t        sel      [NSRC];
    logic            wb_only_a;

    // Purpose: gather the decode sources into indexed form.
    always_comb begin
        src_addr[0] = dof_rs_a_i;
        src_addr[1] = dof_rs_b_i;
        src_use[0]  = dof_use_a_i;
        src_use[1]  = dof_use_b_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hc_src_match #(.AW(AW)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .use_i    (src_use[g]),
            .rs_i     (src_addr[g]),
            .ex_we_i  (ex_we_i),
            .ex_rd_i  (ex_rd_i),
            .ex_hit_o (hit[g])
        );
    end

    hc_policy #(.NSRC(NSRC)) u_policy (
        .clk          (clk),
        .rst_n        (rst_n),
        .fwd_mode_i   (fwd_mode_i),
        .hit_i        (hit),
        .br_taken_i   (br_taken_i),
        .fwd_sel_o    (sel),
        .hold_o       (hold_front_o),
        .dof_bubble_o (dof_bubble_o),
        .if_bubble_o  (if_bubble_o)
    );

    // Purpose: drive the operand mux selects.
    always_comb begin
        fwd_sel_a_o = sel[0];
        fwd_sel_b_o = sel[1];
    end

    // Purpose: flag a source A dependence on write-back alone (checks only).
    always_comb
        wb_only_a = dof_use_a_i && wb_we_i && (wb_rd_i == dof_rs_a_i) &&
                    !(ex_we_i && (ex_rd_i == dof_rs_a_i));

    // R1
    sel_a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_sel_a_o |-> (fwd_mode_i && ex_we_i && ex_rd_i == dof_rs_a_i));

    // R6
    wb_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_only_a && !dof_use_b_i && !br_taken_i) |-> (!hold_front_o && !dof_bubble_o));
endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/100ps
module hazard_ctrl_tb;
    localparam int AW = 5;

    typedef struct packed {
        logic [7:0]    req;
        logic          mode;
        logic          ua;
        logic [AW-1:0] ra;
        logic          ub;
        logic [AW-1:0] rb;
        logic          exwe;
        logic [AW-1:0] exrd;
        logic          wbwe;
        logic [AW-1:0] wbrd;
        logic          br;
        logic [4:0]    exp; // {sel_a, sel_b, hold, dof_bub, if_bub}
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{8'd9,  1'b1,1'b1,5'd3, 1'b1,5'd4, 1'b1,5'd7, 1'b1,5'd8, 1'b0,5'b00000}, // R9
        '{8'd1,  1'b1,1'b1,5'd3, 1'b1,5'd4, 1'b1,5'd3, 1'b0,5'd0, 1'b0,5'b10000}, // R1
        '{8'd2,  1'b1,1'b1,5'd3, 1'b1,5'd4, 1'b1,5'd4, 1'b0,5'd0, 1'b0,5'b01000}, // R2
        '{8'd2,  1'b1,1'b1,5'd6, 1'b1,5'd6, 1'b1,5'd6, 1'b0,5'd0, 1'b0,5'b11000}, // R2 both
        '{8'd3,  1'b1,1'b1,5'd5, 1'b1,5'd2, 1'b1,5'd5, 1'b1,5'd5, 1'b0,5'b10000}, // R3
        '{8'd3,  1'b1,1'b1,5'd5, 1'b1,5'd2, 1'b0,5'd5, 1'b1,5'd5, 1'b0,5'b00000}, // R3 wb only
        '{8'd4,  1'b1,1'b1,5'd0, 1'b1,5'd0, 1'b1,5'd0, 1'b1,5'd0, 1'b0,5'b00000}, // R4
        '{8'd4,  1'b0,1'b1,5'd0, 1'b1,5'd0, 1'b1,5'd0, 1'b0,5'd0, 1'b0,5'b00000}, // R4 stall
        '{8'd5,  1'b0,1'b1,5'd9, 1'b1,5'd4, 1'b1,5'd9, 1'b0,5'd0, 1'b0,5'b00110}, // R5
        '{8'd5,  1'b0,1'b1,5'd1, 1'b1,5'd12,1'b1,5'd12,1'b0,5'd0, 1'b0,5'b00110}, // R5 B
        '{8'd6,  1'b0,1'b1,5'd9, 1'b1,5'd4, 1'b0,5'd0, 1'b1,5'd9, 1'b0,5'b00000}, // R6
        '{8'd7,  1'b0,1'b0,5'd9, 1'b0,5'd4, 1'b1,5'd9, 1'b0,5'd0, 1'b0,5'b00000}, // R7
        '{8'd7,  1'b1,1'b0,5'd9, 1'b1,5'd4, 1'b1,5'd9, 1'b0,5'd0, 1'b0,5'b00000}, // R7 fwd
        '{8'd8,  1'b0,1'b1,5'd9, 1'b1,5'd4, 1'b1,5'd9, 1'b0,5'd0, 1'b1,5'b00011}, // R8
        '{8'd8,  1'b1,1'b1,5'd3, 1'b1,5'd4, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'b10011}, // R8 fwd
        '{8'd10, 1'b1,1'b1,5'd31,1'b1,5'd31,1'b1,5'd31,1'b1,5'd31,1'b0,5'b11000}, // R10
        '{8'd6,  1'b1,1'b1,5'd8, 1'b0,5'd8, 1'b0,5'd8, 1'b1,5'd8, 1'b0,5'b00000}  // R6 fwd
    };

    logic clk = 1'b0;
    logic rst_n;
    logic fwd_mode, ua, ub, exwe, wbwe, br;
    logic [AW-1:0] ra, rb, exrd, wbrd;
    logic sel_a, sel_b, hold, dbub, ibub;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hazard_ctrl #(.AW(AW), .NSRC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .fwd_mode_i(fwd_mode),
        .dof_rs_a_i(ra), .dof_use_a_i(ua), .dof_rs_b_i(rb), .dof_use_b_i(ub),
        .ex_rd_i(exrd), .ex_we_i(exwe), .wb_rd_i(wbrd), .wb_we_i(wbwe),
        .br_taken_i(br), .fwd_sel_a_o(sel_a), .fwd_sel_b_o(sel_b),
        .hold_front_o(hold), .dof_bubble_o(dbub), .if_bubble_o(ibub)
    );

    task automatic apply(input vec_t v);
        @(negedge clk);
        fwd_mode = v.mode; ua = v.ua; ra = v.ra; ub = v.ub; rb = v.rb;
        exwe = v.exwe; exrd = v.exrd; wbwe = v.wbwe; wbrd = v.wbrd; br = v.br;
        #1;
    endtask

    task automatic check(input int req, input logic [4:0] exp);
        logic [4:0] got;
        got = {sel_a, sel_b, hold, dbub, ibub};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        // R11: reset held with a live hazard and forwarding mode requested
        apply('{8'd11, 1'b1,1'b1,5'd3,1'b1,5'd4,1'b1,5'd3,1'b0,5'd0,1'b0,5'b0});
        check(11, 5'b00011);
        apply('{8'd11, 1'b0,1'b1,5'd3,1'b1,5'd4,1'b1,5'd3,1'b0,5'd0,1'b0,5'b0});
        check(11, 5'b00011); // R11 stall mode during reset: no hold
        @(negedge clk);
        rst_n = 1'b1;
        apply('{8'd9, 1'b1,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'b0});
        check(9, 5'b00000); // R9 idle after reset

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(int'(VEC[i].req), VEC[i].exp);
        end

        // R8 corner: branch with a register-0 destination in stall mode
        apply('{8'd8, 1'b0,1'b1,5'd0,1'b1,5'd0,1'b1,5'd0,1'b1,5'd0,1'b1,5'b0});
        check(8, 5'b00011);
        // R4 corner: source 0 used, EX writes a nonzero register
        apply('{8'd4, 1'b0,1'b1,5'd0,1'b0,5'd0,1'b1,5'd2,1'b0,5'd0,1'b0,5'b0});
        check(4, 5'b00000);
        // R5 corner: hazard on B only, A unused but matching
        apply('{8'd5, 1'b0,1'b0,5'd7,1'b1,5'd7,1'b1,5'd7,1'b0,5'd0,1'b0,5'b0});
        check(5, 5'b00110);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule